// File: doc/BRIEF.md
# UART Transmit Engine with Flow Control

This block serialises characters for an asynchronous serial line. A CPU-side write port places one character into a single-entry holding register. The engine moves it into a shift register and sends a start bit, 5 to 8 data bits with the least significant bit first, an optional parity bit, and a stop interval whose length is set in sixteenths of a bit. Bit timing comes from a clock-enable pulse, `tick16`, at sixteen times the bit rate. In 1x mode, each pulse of that input is one whole bit instead.

Two flow-control mechanisms are built in:

- **Clear-to-send gating.** When enabled, the active-low clear-to-send input is looked at only when a character is about to start. While it is high, the line stays marking. Once a character has started, changes on that input do not affect it.
- **Automatic request-to-send negation.** Commands drive the active-low request-to-send output low or high. When automatic negation is on and a transmitter disable is pending, the output returns high one bit time after both registers have emptied.

A disable command never discards characters that were already accepted. Two status outputs report whether the holding register can take a character, and whether the whole transmitter is empty.

Top module: `txe_uart_tx`

## Requirements
- R1: While `rst_n` is low and after reset, `txd`=1, `rtsn`=1, `tx_rdy`=0 and `tx_emt`=0.
- R2: A character is sent as follows.
  - `cfg_len` selects the data length: 00=5, 01=6, 10=7, 11=8 bits.
  - The frame is a start bit (0), then the data bits with the LSB first.
  - Each bit lasts 16 `tick16` pulses. The first bit begins in the clock cycle after the character leaves the holding register.
- R3: With `cfg_par_en`=1, one parity bit follows the data. `cfg_par_odd`=0 makes the count of ones in data plus parity even; `cfg_par_odd`=1 makes it odd.
- R4: In 16x mode, with c = `cfg_stop` (0..15), `txd` stays 1 for a number of `tick16` pulses after the last frame bit:
  - 5-bit characters: 17+c pulses.
  - Longer characters with c<8: 9+c pulses.
  - Longer characters with c>=8: 17+c pulses.
  - Only after this interval can the next character start.
- R5: With `cfg_x1`=1, every `tick16` pulse is one bit. The stop interval is 1 bit when `cfg_stop[3]`=0 and 2 bits when it is 1.
- R6: `tx_rdy` is 1 exactly when the transmitter is enabled and the holding register is empty. A write while `tx_rdy`=0 is ignored.
- R7: `tx_emt` is 1 when the transmitter is enabled and both registers are empty. Right after an enable command from the disabled or reset state, `tx_rdy` and `tx_emt` are both 1.
- R8: CTS gating works as follows.
  - With `cfg_cts_en`=1 and `ctsn`=1, a waiting character does not start and `txd` stays 1. It starts once `ctsn` is 0.
  - With `cfg_cts_en`=0, `ctsn` has no effect.
- R9: A change on `ctsn` while a character is being sent does not alter that character.
- R10: A disable command (`cmd_tx_disable`, which wins over a simultaneous enable) stops new writes. Characters already held or being shifted are still sent in full.
- R11: Automatic negation works as follows.
  - A disable command makes negation pending; an enable command cancels it.
  - With `cfg_auto_rts`=1 and negation pending, once both registers are empty, `rtsn` goes to 1 after 16 `tick16` pulses (1 pulse when `cfg_x1`=1).
- R12: `cmd_rts_assert` drives `rtsn` to 0 in the next cycle, and `cmd_rts_negate` drives it to 1, winning over a simultaneous assert. With `cfg_auto_rts`=0, `rtsn` stays 0 after the transmitter drains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Bit-clock enable, 16 per bit (one per bit in 1x mode) |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character to send |
| cmd_tx_enable | input | 1 | Enable the transmitter (one-cycle pulse) |
| cmd_tx_disable | input | 1 | Disable the transmitter after draining (one-cycle pulse) |
| cmd_rts_assert | input | 1 | Drive rtsn low (one-cycle pulse) |
| cmd_rts_negate | input | 1 | Drive rtsn high (one-cycle pulse) |
| cfg_len | input | 2 | Data length code |
| cfg_par_en | input | 1 | Append a parity bit |
| cfg_par_odd | input | 1 | Odd parity when 1, even when 0 |
| cfg_stop | input | 4 | Stop-length code |
| cfg_x1 | input | 1 | 1x clock mode |
| cfg_cts_en | input | 1 | Gate each character start on ctsn |
| cfg_auto_rts | input | 1 | Automatic rtsn negation after a pending disable |
| ctsn | input | 1 | Active-low clear to send |
| txd | output | 1 | Serial data out, idle high |
| rtsn | output | 1 | Active-low request to send |
| tx_rdy | output | 1 | Holding register can accept a character |
| tx_emt | output | 1 | Holding and shift registers both empty |

## Verification
The per-cycle assertions cover the relations that hold at every edge:

- A disable clears `tx_rdy`.
- An empty transmitter implies a ready one and a marking line.
- A blocked clear-to-send keeps the line high.
- A held character survives a disable.
- The request-to-send commands take effect.
- An automatic rise of `rtsn` happens only from the drained state.

The exact frame contents, parity values, stop lengths in sixteenths, the one-bit delay before automatic negation, and the indifference of a running character to `ctsn` depend on whole sequences. Only the bench scenarios can show them, by comparing `txd`, `rtsn` and the status pins against a reference model on every clock.

// File: rtl/txe_pkg.sv
package txe_pkg;
  localparam int TXE_OVS    = 16;
  localparam int TXE_MAX_DW = 8;
  localparam int TXE_MIN_DW = 5;

  typedef enum logic [1:0] {
    TXE_IDLE = 2'b00,
    TXE_BITS = 2'b01,
    TXE_STOP = 2'b10
  } txe_state_e;
endpackage

// File: rtl/txe_hold.sv
module txe_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          cmd_en,
  input  logic          cmd_dis,
  input  logic          load,
  output logic          hr_full,
  output logic [DW-1:0] hr_data,
  output logic          tx_rdy
);
  logic          en_q, en_d;
  logic          full_q, full_d;
  logic [DW-1:0] data_q, data_d;

  assign tx_rdy  = en_q & ~full_q;
  assign hr_full = full_q;
  assign hr_data = data_q;

  always_comb begin
    en_d   = en_q;
    full_d = full_q;
    data_d = data_q;
    if (cmd_dis)     en_d = 1'b0;
    else if (cmd_en) en_d = 1'b1;
    if (load) begin
      full_d = 1'b0;
    end else if (wr_en && tx_rdy) begin
      full_d = 1'b1;
      data_d = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      en_q   <= en_d;
      full_q <= full_d;
      data_q <= data_d;
    end
  end
endmodule

// File: rtl/txe_shift.sv
module txe_shift
  import txe_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          hr_full,
  input  logic [DW-1:0] hr_data,
  input  logic [1:0]    cfg_len,
  input  logic          cfg_par_en,
  input  logic          cfg_par_odd,
  input  logic [3:0]    cfg_stop,
  input  logic          cfg_x1,
  input  logic          cfg_cts_en,
  input  logic          ctsn,
  output logic          load,
  output logic          idle,
  output logic          txd
);
  localparam int FW     = DW + 2;
  localparam int BCNT_W = $clog2(FW + 1);
  localparam int TCNT_W = $clog2(OVS);
  localparam int SCNT_W = $clog2(2 * OVS + 1);

  txe_state_e        st_q, st_d;
  logic [FW-1:0]     sh_q, sh_d;
  logic [BCNT_W-1:0] bcnt_q, bcnt_d, nb_q, nb_d;
  logic [TCNT_W-1:0] tcnt_q, tcnt_d;
  logic [SCNT_W-1:0] scnt_q, scnt_d, sl_q, sl_d;
  logic              x1_q, x1_d;

  logic [FW-1:0]     frame;
  logic [BCNT_W-1:0] len_n;
  logic [SCNT_W-1:0] stop_n;
  logic              par_bit;
  logic              bit_end;

  assign idle    = (st_q == TXE_IDLE);
  assign load    = idle & hr_full & (~cfg_cts_en | ~ctsn);
  assign txd     = (st_q == TXE_BITS) ? sh_q[0] : 1'b1;
  assign bit_end = x1_q | (tcnt_q == TCNT_W'(OVS - 1));

  // Frame assembly: start, data LSB first, parity, idle fill
  always_comb begin
    len_n   = BCNT_W'(TXE_MIN_DW) + BCNT_W'(cfg_len);
    par_bit = cfg_par_odd;
    for (int i = 0; i < DW; i++)
      if (BCNT_W'(i) < len_n) par_bit = par_bit ^ hr_data[i];
    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < DW; i++) begin
      if (BCNT_W'(i) < len_n)       frame[i+1] = hr_data[i];
      else if (BCNT_W'(i) == len_n) frame[i+1] = par_bit;
    end
    if (len_n == BCNT_W'(DW)) frame[DW+1] = par_bit;
  end

  // Stop length in tick units
  always_comb begin
    if (cfg_x1) begin
      stop_n = cfg_stop[3] ? SCNT_W'(2) : SCNT_W'(1);
    end else begin
      stop_n = SCNT_W'(OVS + 1) + SCNT_W'(cfg_stop);
      if (cfg_len != 2'b00 && !cfg_stop[3]) stop_n = stop_n - SCNT_W'(OVS / 2);
    end
  end

  always_comb begin
    st_d   = st_q;
    sh_d   = sh_q;
    bcnt_d = bcnt_q;
    nb_d   = nb_q;
    tcnt_d = tcnt_q;
    scnt_d = scnt_q;
    sl_d   = sl_q;
    x1_d   = x1_q;
    unique case (st_q)
      TXE_IDLE: if (load) begin
        st_d   = TXE_BITS;
        sh_d   = frame;
        nb_d   = BCNT_W'(1) + len_n + BCNT_W'(cfg_par_en);
        sl_d   = stop_n;
        x1_d   = cfg_x1;
        bcnt_d = '0;
        tcnt_d = '0;
      end
      TXE_BITS: if (tick) begin
        if (bit_end) begin
          tcnt_d = '0;
          if (bcnt_q == nb_q - BCNT_W'(1)) begin
            st_d   = TXE_STOP;
            scnt_d = '0;
          end else begin
            sh_d   = {1'b1, sh_q[FW-1:1]};
            bcnt_d = bcnt_q + BCNT_W'(1);
          end
        end else begin
          tcnt_d = tcnt_q + TCNT_W'(1);
        end
      end
      TXE_STOP: if (tick) begin
        if (scnt_q == sl_q - SCNT_W'(1)) st_d = TXE_IDLE;
        else scnt_d = scnt_q + SCNT_W'(1);
      end
      default: st_d = TXE_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TXE_IDLE;
      sh_q   <= '1;
      bcnt_q <= '0;
      nb_q   <= '0;
      tcnt_q <= '0;
      scnt_q <= '0;
      sl_q   <= '0;
      x1_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      sh_q   <= sh_d;
      bcnt_q <= bcnt_d;
      nb_q   <= nb_d;
      tcnt_q <= tcnt_d;
      scnt_q <= scnt_d;
      sl_q   <= sl_d;
      x1_q   <= x1_d;
    end
  end
endmodule

// File: rtl/txe_rts.sv
module txe_rts #(
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic cfg_x1,
  input  logic cfg_auto_rts,
  input  logic cmd_en,
  input  logic cmd_dis,
  input  logic cmd_assert,
  input  logic cmd_negate,
  input  logic drained,
  output logic rtsn
);
  localparam int RW = $clog2(OVS);

  logic          pend_q, pend_d;
  logic          rtsn_q, rtsn_d;
  logic [RW-1:0] rcnt_q, rcnt_d;
  logic          armed, fire;

  assign armed = cfg_auto_rts & pend_q & drained;
  assign fire  = armed & tick & (cfg_x1 | (rcnt_q == RW'(OVS - 1)));
  assign rtsn  = rtsn_q;

  always_comb begin
    if (!armed)    rcnt_d = '0;
    else if (fire) rcnt_d = '0;
    else if (tick) rcnt_d = rcnt_q + RW'(1);
    else           rcnt_d = rcnt_q;

    if (cmd_dis)     pend_d = 1'b1;
    else if (cmd_en) pend_d = 1'b0;
    else if (fire)   pend_d = 1'b0;
    else             pend_d = pend_q;

    if (cmd_negate || fire) rtsn_d = 1'b1;
    else if (cmd_assert)    rtsn_d = 1'b0;
    else                    rtsn_d = rtsn_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      rtsn_q <= 1'b1;
      rcnt_q <= '0;
    end else begin
      pend_q <= pend_d;
      rtsn_q <= rtsn_d;
      rcnt_q <= rcnt_d;
    end
  end
endmodule

// File: rtl/txe_uart_tx.sv
module txe_uart_tx
  import txe_pkg::*;
#(
  parameter int DW  = TXE_MAX_DW,
  parameter int OVS = TXE_OVS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick16,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          cmd_tx_enable,
  input  logic          cmd_tx_disable,
  input  logic          cmd_rts_assert,
  input  logic          cmd_rts_negate,
  input  logic [1:0]    cfg_len,
  input  logic          cfg_par_en,
  input  logic          cfg_par_odd,
  input  logic [3:0]    cfg_stop,
  input  logic          cfg_x1,
  input  logic          cfg_cts_en,
  input  logic          cfg_auto_rts,
  input  logic          ctsn,
  output logic          txd,
  output logic          rtsn,
  output logic          tx_rdy,
  output logic          tx_emt
);
  logic          hr_full;
  logic [DW-1:0] hr_data;
  logic          load;
  logic          sh_idle;

  assign tx_emt = tx_rdy & sh_idle;

  txe_hold #(.DW(DW)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .cmd_en  (cmd_tx_enable),
    .cmd_dis (cmd_tx_disable),
    .load    (load),
    .hr_full (hr_full),
    .hr_data (hr_data),
    .tx_rdy  (tx_rdy)
  );

  txe_shift #(.DW(DW), .OVS(OVS)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick16),
    .hr_full     (hr_full),
    .hr_data     (hr_data),
    .cfg_len     (cfg_len),
    .cfg_par_en  (cfg_par_en),
    .cfg_par_odd (cfg_par_odd),
    .cfg_stop    (cfg_stop),
    .cfg_x1      (cfg_x1),
    .cfg_cts_en  (cfg_cts_en),
    .ctsn        (ctsn),
    .load        (load),
    .idle        (sh_idle),
    .txd         (txd)
  );

  txe_rts #(.OVS(OVS)) u_rts (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick16),
    .cfg_x1       (cfg_x1),
    .cfg_auto_rts (cfg_auto_rts),
    .cmd_en       (cmd_tx_enable),
    .cmd_dis      (cmd_tx_disable),
    .cmd_assert   (cmd_rts_assert),
    .cmd_negate   (cmd_rts_negate),
    .drained      (sh_idle & ~hr_full),
    .rtsn         (rtsn)
  );
endmodule

// File: rtl/txe_uart_tx_chk.sv
module txe_uart_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_tx_disable,
  input logic cmd_rts_assert,
  input logic cmd_rts_negate,
  input logic cfg_cts_en,
  input logic ctsn,
  input logic txd,
  input logic rtsn,
  input logic tx_rdy,
  input logic tx_emt,
  input logic sh_idle,
  input logic hr_full
);
  assert_disable_blocks_rdy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_tx_disable |=> !tx_rdy);

  assert_emt_implies_rdy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_emt |-> (tx_rdy && txd));

  assert_cts_blocks_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_cts_en && ctsn && sh_idle) |=> txd);

  assert_disable_keeps_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hr_full && cmd_tx_disable) |=> (hr_full || !sh_idle));

  assert_auto_rise_drained_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rtsn) && !$past(cmd_rts_negate)) |-> $past(sh_idle && !hr_full));

  assert_rts_assert_cmd_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rts_assert && !cmd_rts_negate) |=> !rtsn);

  assert_rts_negate_cmd_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rts_negate |=> rtsn);
endmodule

bind txe_uart_tx txe_uart_tx_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cmd_tx_disable (cmd_tx_disable),
  .cmd_rts_assert (cmd_rts_assert),
  .cmd_rts_negate (cmd_rts_negate),
  .cfg_cts_en     (cfg_cts_en),
  .ctsn           (ctsn),
  .txd            (txd),
  .rtsn           (rtsn),
  .tx_rdy         (tx_rdy),
  .tx_emt         (tx_emt),
  .sh_idle        (sh_idle),
  .hr_full        (hr_full)
);

// File: tb/txe_uart_tx_tb_top.sv
module txe_uart_tx_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick16 = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic cmd_tx_enable = 1'b0, cmd_tx_disable = 1'b0;
  logic cmd_rts_assert = 1'b0, cmd_rts_negate = 1'b0;
  logic [1:0] cfg_len = 2'b11;
  logic cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
  logic [3:0] cfg_stop = 4'd7;
  logic cfg_x1 = 1'b0, cfg_cts_en = 1'b0, cfg_auto_rts = 1'b0;
  logic ctsn = 1'b0;
  logic txd, rtsn, tx_rdy, tx_emt;

  int checks = 0;
  int fails = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  txe_uart_tx dut_i (.*);

  // Tick enable: one pulse every third clock
  initial begin
    int n = 0;
    forever begin
      @(negedge clk);
      n++;
      tick16 = (n % 3 == 0);
    end
  end

  // Reference model
  bit lvq[$];
  bit m_en, m_full, m_pend, m_rtsn;
  int m_rcnt;

  function automatic int stop_ticks(bit [1:0] len, bit [3:0] c, bit x1);
    if (x1) return c[3] ? 2 : 1;
    if (len == 2'b00) return 17 + int'(c);
    if (c < 8) return 9 + int'(c);
    return 17 + int'(c);
  endfunction

  task automatic push_level(bit v, int n);
    for (int k = 0; k < n; k++) lvq.push_back(v);
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvq.delete();
      m_en = 0; m_full = 0; m_pend = 0; m_rtsn = 1; m_rcnt = 0;
    end else begin
      bit idle0, full0, rdy0, pend0, armed, fire;
      idle0 = (lvq.size() == 0);
      full0 = m_full;
      rdy0  = m_en && !m_full;
      pend0 = m_pend;
      if (tick16 && !idle0) void'(lvq.pop_front());
      if (idle0 && full0 && (!cfg_cts_en || !ctsn)) begin
        int bt, len, ones;
        bt = cfg_x1 ? 1 : 16;
        len = 5 + int'(cfg_len);
        ones = 0;
        push_level(1'b0, bt);
        for (int b = 0; b < len; b++) begin
          push_level(m_data[b], bt);
          ones += m_data[b];
        end
        if (cfg_par_en) push_level(bit'(ones % 2) ^ cfg_par_odd, bt);
        push_level(1'b1, stop_ticks(cfg_len, cfg_stop, cfg_x1));
        m_full = 0;
      end else if (wr_en && rdy0) begin
        m_full = 1;
        m_data = wr_data;
      end
      if (cmd_tx_disable) m_en = 0;
      else if (cmd_tx_enable) m_en = 1;
      armed = cfg_auto_rts && pend0 && idle0 && !full0;
      fire = 0;
      if (!armed) m_rcnt = 0;
      else if (tick16) begin
        if (cfg_x1 || m_rcnt == 15) begin fire = 1; m_rcnt = 0; end
        else m_rcnt++;
      end
      if (cmd_tx_disable) m_pend = 1;
      else if (cmd_tx_enable || fire) m_pend = 0;
      if (cmd_rts_negate || fire) m_rtsn = 1;
      else if (cmd_rts_assert) m_rtsn = 0;
    end
  end
  bit [7:0] m_data;

  task automatic chk(logic act, logic exp, string req, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        chk(txd, (lvq.size() != 0) ? lvq[0] : 1'b1, cur_req, "txd");
        chk(tx_rdy, m_en && !m_full, "R6", "tx_rdy");
        chk(tx_emt, m_en && !m_full && lvq.size() == 0, "R7", "tx_emt");
        chk(rtsn, m_rtsn, (cur_req == "R12") ? "R12" : "R11", "rtsn");
      end
    end
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  task automatic put(logic [7:0] d);
    @(negedge clk);
    while (!tx_rdy) @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk);
    while (lvq.size() != 0 || m_full) @(negedge clk);
    run(3);
  endtask

  task automatic cfg(logic [1:0] l, logic pe, logic po, logic [3:0] s, logic x);
    cfg_len = l; cfg_par_en = pe; cfg_par_odd = po; cfg_stop = s; cfg_x1 = x;
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    cur_req = "R1";
    run(3);
    chk(txd, 1'b1, "R1", "txd in reset");
    chk(rtsn, 1'b1, "R1", "rtsn in reset");
    chk(tx_rdy, 1'b0, "R1", "tx_rdy in reset");
    rst_n = 1'b1;
    run(2);
    chk(tx_emt, 1'b0, "R1", "tx_emt after reset");

    // R6: write while disabled is ignored
    cur_req = "R6";
    @(negedge clk); wr_en = 1'b1; wr_data = 8'h00;
    @(negedge clk); wr_en = 1'b0;
    pulse(cmd_tx_enable);
    run(1);
    chk(tx_rdy, 1'b1, "R7", "tx_rdy after enable");
    chk(tx_emt, 1'b1, "R7", "tx_emt after enable (underrun)");
    run(40);
    chk(txd, 1'b1, "R6", "line idle after ignored write");

    // R2: 8-bit and 6-bit, no parity
    cur_req = "R2";
    cfg(2'b11, 0, 0, 4'd7, 0); put(8'hA5); drain();
    cfg(2'b01, 0, 0, 4'd3, 0); put(8'h2C); drain();

    // R3: parity
    cur_req = "R3";
    cfg(2'b10, 1, 0, 4'd7, 0); put(8'h53); drain();
    cfg(2'b10, 1, 1, 4'd7, 0); put(8'h53); drain();
    cfg(2'b11, 1, 1, 4'd15, 0); put(8'hFF); drain();

    // R4: stop lengths, back-to-back characters
    cur_req = "R4";
    cfg(2'b00, 0, 0, 4'd0, 0); put(8'h15); put(8'h0A); drain();
    cfg(2'b00, 1, 0, 4'd15, 0); put(8'h1F); put(8'h01); drain();
    cfg(2'b11, 0, 0, 4'd0, 0); put(8'h81); put(8'h7E); drain();
    cfg(2'b11, 0, 0, 4'd8, 0); put(8'h3C); put(8'hC3); drain();

    // R5: 1x mode
    cur_req = "R5";
    cfg(2'b11, 0, 0, 4'd0, 1); put(8'h96); put(8'h69); drain();
    cfg(2'b00, 1, 1, 4'd8, 1); put(8'h0B); put(8'h14); drain();
    cfg(2'b11, 0, 0, 4'd7, 0);

    // R6: third write while holding register is full
    cur_req = "R6";
    put(8'h11); put(8'h22);
    chk(tx_rdy, 1'b0, "R6", "tx_rdy with full holding register");
    @(negedge clk); wr_en = 1'b1; wr_data = 8'h33;
    @(negedge clk); wr_en = 1'b0;
    drain();

    // R8: CTS gating
    cur_req = "R8";
    cfg_cts_en = 1'b1; ctsn = 1'b1;
    put(8'h5A);
    run(300);
    chk(txd, 1'b1, "R8", "txd held while ctsn high");
    chk(tx_emt, 1'b0, "R8", "character still waiting");
    ctsn = 1'b0;
    run(3);
    chk(txd, 1'b0, "R8", "start bit after ctsn low");
    drain();
    cfg_cts_en = 1'b0; ctsn = 1'b1;
    put(8'hE7); run(3);
    chk(txd, 1'b0, "R8", "ctsn ignored when gating off");
    drain();

    // R9: ctsn rises mid-character
    cur_req = "R9";
    cfg_cts_en = 1'b1; ctsn = 1'b0;
    put(8'h0F);
    run(60);
    ctsn = 1'b1;
    drain();
    chk(tx_emt, 1'b1, "R9", "character completed despite ctsn");
    cfg_cts_en = 1'b0; ctsn = 1'b0;

    // R10 / R11: auto RTS after pending disable
    cur_req = "R10";
    cfg_auto_rts = 1'b1;
    pulse(cmd_rts_assert);
    put(8'h4D); put(8'hB2);
    pulse(cmd_tx_disable);
    run(1);
    chk(tx_rdy, 1'b0, "R10", "tx_rdy after disable");
    drain();
    cur_req = "R11";
    chk(rtsn, 1'b0, "R11", "rtsn still low at drain");
    run(60);
    chk(rtsn, 1'b1, "R11", "rtsn negated one bit after drain");

    // R11 in 1x mode, disable from underrun
    cfg_x1 = 1'b1;
    pulse(cmd_tx_enable);
    pulse(cmd_rts_assert);
    put(8'h99);
    run(2);
    pulse(cmd_tx_disable);
    drain();
    run(6);
    chk(rtsn, 1'b1, "R11", "rtsn negated in 1x mode");
    cfg_x1 = 1'b0;

    // R12: manual control without auto negation
    cur_req = "R12";
    cfg_auto_rts = 1'b0;
    pulse(cmd_tx_enable);
    pulse(cmd_rts_assert);
    run(1);
    chk(rtsn, 1'b0, "R12", "rtsn after assert command");
    put(8'h42);
    pulse(cmd_tx_disable);
    drain();
    run(100);
    chk(rtsn, 1'b0, "R12", "rtsn held without auto mode");
    @(negedge clk); cmd_rts_assert = 1'b1; cmd_rts_negate = 1'b1;
    @(negedge clk); cmd_rts_assert = 1'b0; cmd_rts_negate = 1'b0;
    chk(rtsn, 1'b1, "R12", "negate wins over assert");
    run(5);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule